// File: doc/BRIEF.md
# Instruction Prefix Capture and Field Extender

This block sits in an instruction decode stage. It watches a stream of instruction words that upstream logic has already split and tagged with a length class and a "prefix candidate" flag. A prefix word carries a short payload. The block keeps that payload in its own local copy, so the next instruction can use it in the very next cycle without waiting on any control-register write. The block then applies the payload to the next ordinary instruction. For that instruction it produces 7-bit register numbers, a vector-width selector and a predicate control, and then it drops the payload.

Only one prefix may govern an instruction. A prefix that arrives while another prefix is still pending does not stack on it. The two prefix words are reported together as one alternate operation, and both raw payloads are handed onward for a later decode step. A flush input discards the pending payload and the word offered in the same cycle. Every result is registered and appears one cycle after the word that caused it.

Top module: `insn_prefix_decoder`

## Requirements
- R1: During and right after reset, out_valid is 0, out_alt is 0, the register, width, length and payload outputs are 0, and out_pred_inv and out_pred_none are 1.
- R2: A word with in_pfx=1 and length code 2 (48-bit class) or 3 (64-bit class) is a prefix, and a first prefix produces no output. Length codes are 0=16-bit, 1=32-bit, 2=48-bit and 3=64-bit. A word with in_pfx=1 and length code 0 or 1 is handled as an ordinary instruction.
- R3: The payload bits are laid out as follows: [1:0] vector-width code (0=default, use the vector-length register; 1=2; 2=3; 3=4), [3:2] destination extension NN, [5:4] source extension shared by both sources, [6] predicate invert, [9:7] predicate code. A 64-bit-class prefix carries 9 payload bits, so its bit 9 is read as 0.
- R4: Predicate code 0 selects register 0, and code c>0 selects register 8+c. out_pred_none is 1 exactly when the invert bit is set and register 0 is selected (all lanes enabled).
- R5: For an ordinary instruction of length code 1, 2 or 3, each 7-bit register output is {NN, 5-bit input field}.
- R6: For an ordinary 16-bit instruction, only the low 3 bits nnn of each field are used. The output depends on the width code: code 0 gives 00NNnnn, code 1 gives 0NNnnn0, and codes 2 and 3 give NNnnn00.
- R7: A pending payload applies to exactly the next ordinary instruction, even after idle cycles, and is then cleared. The instruction after that is unprefixed.
- R8: An ordinary instruction with no pending payload is output with NN=0, width code 0, out_pred_inv=1, out_pred_reg=0 and out_pred_none=1.
- R9: A prefix that arrives while a payload is pending produces one output with out_alt=1. That output has out_alt_first set to the pending payload and out_alt_second set to the new payload (both masked per R3), out_len set to the new prefix's length, register and width outputs at 0, and the no-predicate setting. No payload remains pending afterwards.
- R10: While flush is 1, any pending payload is cleared, the offered word is discarded, and no output follows.
- R11: Each accepted ordinary instruction or alternate pair gives out_valid=1 for exactly one cycle, in the cycle after it is offered. out_valid is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard pending prefix and current word |
| in_valid | input | 1 | A word is offered this cycle |
| in_len | input | 2 | Length class of the word |
| in_pfx | input | 1 | Word is a prefix candidate |
| in_payload | input | 10 | Prefix payload bits |
| in_rd | input | 5 | Destination register field |
| in_rs1 | input | 5 | First source register field |
| in_rs2 | input | 5 | Second source register field |
| out_valid | output | 1 | Result valid |
| out_alt | output | 1 | Result is a doubled-prefix alternate operation |
| out_len | output | 2 | Length class of the word producing the result |
| out_rd | output | 7 | Extended destination register |
| out_rs1 | output | 7 | Extended first source register |
| out_rs2 | output | 7 | Extended second source register |
| out_vw | output | 2 | Vector-width code |
| out_pred_inv | output | 1 | Predicate invert |
| out_pred_reg | output | 5 | Predicate register number |
| out_pred_none | output | 1 | No predication (inverted register 0) |
| out_alt_first | output | 10 | First prefix payload of an alternate pair |
| out_alt_second | output | 10 | Second prefix payload of an alternate pair |

## Verification
On every cycle, the assertions check the following: a flush or a consumed payload leaves nothing pending; a lone first prefix, an idle cycle or a flush is followed by no result; alternate results carry zeroed register fields; the predicate register stays in its legal set; and the narrow placements keep their zero padding. Only the scenarios in the bench can show that the right payload reaches the right instruction. They cover the exact bit placement for each width code, the 9-bit masking of the 64-bit class, the way a pair of prefixes is reported, and the state after the pair and after a flush.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int REG_W   = 5;
  localparam int CREG_W  = 3;
  localparam int EXT_W   = 2;
  localparam int XREG_W  = REG_W + EXT_W;
  localparam int VW_W    = 2;
  localparam int PCODE_W = 3;
  localparam int PAY_W   = PCODE_W + 1 + 2 * EXT_W + VW_W;
  localparam int PREG_BASE = 8;
  localparam int NFIELD  = 3;

  typedef enum logic [1:0] {LEN16 = 2'd0, LEN32 = 2'd1, LEN48 = 2'd2, LEN64 = 2'd3} ilen_e;

  typedef struct packed {
    logic [PCODE_W-1:0] pcode;
    logic               inv;
    logic [EXT_W-1:0]   rs_x;
    logic [EXT_W-1:0]   rd_x;
    logic [VW_W-1:0]    vw;
  } pfx_pay_t;

  localparam pfx_pay_t DEFAULT_PAY = '{pcode: '0, inv: 1'b1, rs_x: '0, rd_x: '0, vw: '0};

  function automatic pfx_pay_t mask_pay(input logic [PAY_W-1:0] raw, input ilen_e len);
    logic [PAY_W-1:0] m;
    m = raw;
    if (len == LEN64) m[PAY_W-1] = 1'b0;
    return pfx_pay_t'(m);
  endfunction
endpackage

// File: rtl/pfx_state.sv
module pfx_state
  import pfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  input  ilen_e            in_len,
  input  logic             in_pfx,
  input  logic [PAY_W-1:0] in_payload,
  output logic             acc_ord,
  output logic             acc_alt,
  output pfx_pay_t         cur_pay,
  output logic             pend_vld,
  output pfx_pay_t         pend_pay
);
  logic is_pfx;
  logic take;

  always_comb begin
    is_pfx  = in_pfx && (in_len == LEN48 || in_len == LEN64);
    take    = in_valid && !flush;
    acc_ord = take && !is_pfx;
    acc_alt = take && is_pfx && pend_vld;
    cur_pay = mask_pay(in_payload, in_len);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_vld <= 1'b0;
      pend_pay <= DEFAULT_PAY;
    end else if (take) begin
      if (is_pfx && !pend_vld) begin
        pend_vld <= 1'b1;
        pend_pay <= cur_pay;
      end else begin
        pend_vld <= 1'b0;
        pend_pay <= DEFAULT_PAY;
      end
    end
  end

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pend_vld);

  p_consume_once_r7: assert property (@(posedge clk) disable iff (rst)
    acc_ord |=> !pend_vld);

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flush) |=> $stable(pend_vld));
endmodule

// File: rtl/pfx_field_ext.sv
module pfx_field_ext
  import pfx_pkg::*;
#(
  parameter int NF = NFIELD
) (
  input  ilen_e                          len,
  input  logic [VW_W-1:0]                vw,
  input  logic [NF-1:0][REG_W-1:0]       fld_in,
  input  logic [NF-1:0][EXT_W-1:0]       ext_in,
  output logic [NF-1:0][XREG_W-1:0]      fld_out
);
  localparam int NARROW_W = CREG_W + EXT_W;
  localparam int MAXSH    = XREG_W - NARROW_W;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [XREG_W-1:0] narrow_z;
    logic [XREG_W-1:0] placed;
    logic [XREG_W-1:0] wide;

    always_comb begin
      narrow_z = XREG_W'({ext_in[g], fld_in[g][CREG_W-1:0]});
      wide     = {ext_in[g], fld_in[g]};
      case (vw)
        2'd0:    placed = narrow_z;
        2'd1:    placed = narrow_z << 1;
        default: placed = narrow_z << MAXSH;
      endcase
      fld_out[g] = (len == LEN16) ? placed : wide;
    end

    always_comb begin
      if (len == LEN16 && vw[1]) begin
        p_narrow_pad_r6: assert (fld_out[g][MAXSH-1:0] == '0);
      end
    end
  end
endmodule

// File: rtl/pfx_pred_map.sv
module pfx_pred_map
  import pfx_pkg::*;
(
  input  pfx_pay_t   pay,
  output logic       pred_inv,
  output logic [REG_W-1:0] pred_reg,
  output logic       pred_none
);
  always_comb begin
    pred_inv  = pay.inv;
    pred_reg  = (pay.pcode == '0) ? '0 : REG_W'(PREG_BASE) + REG_W'(pay.pcode);
    pred_none = pay.inv && (pay.pcode == '0);
  end

  always_comb begin
    p_pred_range_r4: assert (pred_reg == '0 ||
      (pred_reg > REG_W'(PREG_BASE) && pred_reg < REG_W'(PREG_BASE + (1 << PCODE_W))));
  end
endmodule

// File: rtl/insn_prefix_decoder.sv
module insn_prefix_decoder
  import pfx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                in_valid,
  input  logic [1:0]          in_len,
  input  logic                in_pfx,
  input  logic [PAY_W-1:0]    in_payload,
  input  logic [REG_W-1:0]    in_rd,
  input  logic [REG_W-1:0]    in_rs1,
  input  logic [REG_W-1:0]    in_rs2,
  output logic                out_valid,
  output logic                out_alt,
  output logic [1:0]          out_len,
  output logic [XREG_W-1:0]   out_rd,
  output logic [XREG_W-1:0]   out_rs1,
  output logic [XREG_W-1:0]   out_rs2,
  output logic [VW_W-1:0]     out_vw,
  output logic                out_pred_inv,
  output logic [REG_W-1:0]    out_pred_reg,
  output logic                out_pred_none,
  output logic [PAY_W-1:0]    out_alt_first,
  output logic [PAY_W-1:0]    out_alt_second
);
  ilen_e    len_e;
  logic     acc_ord, acc_alt, pend_vld;
  pfx_pay_t cur_pay, pend_pay, eff_pay;
  logic [NFIELD-1:0][REG_W-1:0]  fld_in;
  logic [NFIELD-1:0][EXT_W-1:0]  ext_in;
  logic [NFIELD-1:0][XREG_W-1:0] fld_out;
  logic             p_inv, p_none;
  logic [REG_W-1:0] p_reg;

  assign len_e = ilen_e'(in_len);

  pfx_state u_state (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .in_valid   (in_valid),
    .in_len     (len_e),
    .in_pfx     (in_pfx),
    .in_payload (in_payload),
    .acc_ord    (acc_ord),
    .acc_alt    (acc_alt),
    .cur_pay    (cur_pay),
    .pend_vld   (pend_vld),
    .pend_pay   (pend_pay)
  );

  always_comb begin
    eff_pay   = pend_vld ? pend_pay : DEFAULT_PAY;
    fld_in[0] = in_rd;
    fld_in[1] = in_rs1;
    fld_in[2] = in_rs2;
    ext_in[0] = eff_pay.rd_x;
    ext_in[1] = eff_pay.rs_x;
    ext_in[2] = eff_pay.rs_x;
  end

  pfx_field_ext #(.NF(NFIELD)) u_ext (
    .len     (len_e),
    .vw      (eff_pay.vw),
    .fld_in  (fld_in),
    .ext_in  (ext_in),
    .fld_out (fld_out)
  );

  pfx_pred_map u_pred (
    .pay       (eff_pay),
    .pred_inv  (p_inv),
    .pred_reg  (p_reg),
    .pred_none (p_none)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_alt        <= 1'b0;
      out_len        <= '0;
      out_rd         <= '0;
      out_rs1        <= '0;
      out_rs2        <= '0;
      out_vw         <= '0;
      out_pred_inv   <= 1'b1;
      out_pred_reg   <= '0;
      out_pred_none  <= 1'b1;
      out_alt_first  <= '0;
      out_alt_second <= '0;
    end else begin
      out_valid <= acc_ord || acc_alt;
      if (acc_ord) begin
        out_alt        <= 1'b0;
        out_len        <= in_len;
        out_rd         <= fld_out[0];
        out_rs1        <= fld_out[1];
        out_rs2        <= fld_out[2];
        out_vw         <= eff_pay.vw;
        out_pred_inv   <= p_inv;
        out_pred_reg   <= p_reg;
        out_pred_none  <= p_none;
        out_alt_first  <= '0;
        out_alt_second <= '0;
      end else if (acc_alt) begin
        out_alt        <= 1'b1;
        out_len        <= in_len;
        out_rd         <= '0;
        out_rs1        <= '0;
        out_rs2        <= '0;
        out_vw         <= '0;
        out_pred_inv   <= 1'b1;
        out_pred_reg   <= '0;
        out_pred_none  <= 1'b1;
        out_alt_first  <= pend_pay;
        out_alt_second <= cur_pay;
      end
    end
  end

  p_idle_silent_r11: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !flush) |=> !out_valid);

  p_flush_silent_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  p_first_prefix_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flush && in_pfx && in_len[1] && !pend_vld) |=> !out_valid);

  p_alt_defaults_r9: assert property (@(posedge clk) disable iff (rst)
    out_alt |-> (out_pred_none && out_rd == '0 && out_rs1 == '0 &&
                 out_rs2 == '0 && out_vw == '0));
endmodule

// File: tb/insn_prefix_decoder_tb_top.sv
module insn_prefix_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 53;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, in_valid = 1'b0, in_pfx = 1'b0;
  logic [1:0] in_len = '0;
  logic [9:0] in_payload = '0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic out_valid, out_alt, out_pred_inv, out_pred_none;
  logic [1:0] out_len, out_vw;
  logic [6:0] out_rd, out_rs1, out_rs2;
  logic [4:0] out_pred_reg;
  logic [9:0] out_alt_first, out_alt_second;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [VEC_W-1:0] v;
    string tag;
  } exp_t;
  exp_t sb[$];

  bit m_pend = 0;
  logic [9:0] m_pay = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_prefix_decoder dut_i (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_len(in_len),
    .in_pfx(in_pfx), .in_payload(in_payload), .in_rd(in_rd), .in_rs1(in_rs1),
    .in_rs2(in_rs2), .out_valid(out_valid), .out_alt(out_alt), .out_len(out_len),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_vw(out_vw),
    .out_pred_inv(out_pred_inv), .out_pred_reg(out_pred_reg),
    .out_pred_none(out_pred_none), .out_alt_first(out_alt_first),
    .out_alt_second(out_alt_second)
  );

  function automatic logic [VEC_W-1:0] actual_vec();
    return {out_alt, out_len, out_rd, out_rs1, out_rs2, out_vw, out_pred_inv,
            out_pred_reg, out_pred_none, out_alt_first, out_alt_second};
  endfunction

  function automatic logic [9:0] mk(input logic [2:0] code, input logic inv,
                                    input logic [1:0] rsx, input logic [1:0] rdx,
                                    input logic [1:0] vw);
    return {code, inv, rsx, rdx, vw};
  endfunction

  // R6 placement, written from the literal patterns
  function automatic logic [6:0] place(input logic [1:0] len, input logic [1:0] vw,
                                       input logic [1:0] nn, input logic [4:0] f);
    if (len != 2'd0) return {nn, f};
    case (vw)
      2'd0:    return {2'b00, nn, f[2:0]};
      2'd1:    return {1'b0, nn, f[2:0], 1'b0};
      default: return {nn, f[2:0], 2'b00};
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] ord_vec(input logic [1:0] len, input logic [9:0] p,
                                               input logic [4:0] rd, input logic [4:0] rs1,
                                               input logic [4:0] rs2);
    logic [4:0] preg;
    logic none;
    preg = (p[9:7] == 3'd0) ? 5'd0 : 5'd8 + {2'b00, p[9:7]};
    none = p[6] && (p[9:7] == 3'd0);
    return {1'b0, len, place(len, p[1:0], p[3:2], rd), place(len, p[1:0], p[5:4], rs1),
            place(len, p[1:0], p[5:4], rs2), p[1:0], p[6], preg, none, 10'd0, 10'd0};
  endfunction

  task automatic drive(input logic [1:0] len, input logic pfx, input logic [9:0] pay,
                       input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                       input logic fl, input string tag);
    logic [9:0] mp;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_len = len; in_pfx = pfx; in_payload = pay;
    in_rd = rd; in_rs1 = rs1; in_rs2 = rs2; flush = fl;
    mp = pay;
    if (len == 2'd3) mp[9] = 1'b0;
    e.tag = tag;
    if (fl) begin
      m_pend = 0;
    end else if (pfx && len[1]) begin
      if (m_pend) begin
        e.v = {1'b1, len, 21'd0, 2'd0, 1'b1, 5'd0, 1'b1, m_pay, mp};
        sb.push_back(e);
        m_pend = 0;
      end else begin
        m_pend = 1;
        m_pay = mp;
      end
    end else begin
      e.v = ord_vec(len, m_pend ? m_pay : 10'h040, rd, rs1, rs2);
      sb.push_back(e);
      m_pend = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; flush = 1'b0; in_pfx = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected result: actual %h expected none", actual_vec());
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (actual_vec() !== e.v) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", e.tag, actual_vec(), e.v);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || actual_vec() !== {32'd0, 1'b1, 5'd0, 1'b1, 20'd0}) begin
      errors++;
      $display("FAIL R1 reset state: actual %b/%h expected 0/%h", out_valid, actual_vec(),
               {32'd0, 1'b1, 5'd0, 1'b1, 20'd0});
    end
    rst = 1'b0;
    idle(1);

    drive(2'd1, 0, 10'h3ff, 5'd5, 5'd17, 5'd31, 0, "R8 unprefixed 32-bit");
    drive(2'd0, 0, 10'h000, 5'b11101, 5'd2, 5'd7, 0, "R6 R8 unprefixed 16-bit");
    drive(2'd0, 1, 10'h3ff, 5'd3, 5'd4, 5'd6, 0, "R2 prefix flag on 16-bit is ordinary");
    drive(2'd1, 1, 10'h155, 5'd9, 5'd1, 5'd0, 0, "R2 prefix flag on 32-bit is ordinary");

    drive(2'd2, 1, mk(3'd1, 0, 2'd1, 2'd3, 2'd0), 0, 0, 0, 0, "R2 prefix");
    drive(2'd1, 0, 0, 5'd10, 5'd20, 5'd30, 0, "R3 R4 R5 prefixed 32-bit");
    drive(2'd1, 0, 0, 5'd10, 5'd20, 5'd30, 0, "R7 second instruction unprefixed");

    for (int w = 0; w < 4; w++) begin
      drive(2'd2, 1, mk(3'd7, 1, 2'd2, 2'd1, 2'(w)), 0, 0, 0, 0, "R6 prefix");
      drive(2'd0, 0, 0, 5'b11011, 5'd5, 5'd2, 0, $sformatf("R6 16-bit width code %0d", w));
    end

    drive(2'd3, 1, mk(3'd7, 0, 2'd3, 2'd2, 2'd3), 0, 0, 0, 0, "R3 64-bit prefix");
    drive(2'd3, 0, 0, 5'd1, 5'd2, 5'd3, 0, "R3 R5 64-class masks bit 9");
    drive(2'd2, 1, mk(3'd0, 1, 2'd1, 2'd1, 2'd1), 0, 0, 0, 0, "R4 prefix");
    drive(2'd2, 0, 0, 5'd4, 5'd8, 5'd12, 0, "R4 inverted x0 no predication");
    drive(2'd2, 1, mk(3'd0, 0, 2'd0, 2'd0, 2'd2), 0, 0, 0, 0, "R4 prefix");
    drive(2'd1, 0, 0, 5'd4, 5'd8, 5'd12, 0, "R4 plain x0 is predicated");

    drive(2'd2, 1, mk(3'd2, 0, 2'd3, 2'd3, 2'd1), 0, 0, 0, 0, "R7 prefix");
    idle(3);
    drive(2'd0, 0, 0, 5'd1, 5'd6, 5'd3, 0, "R7 applies after idle gap");

    drive(2'd2, 1, mk(3'd3, 0, 2'd1, 2'd2, 2'd1), 0, 0, 0, 0, "R9 first");
    drive(2'd3, 1, 10'h3ff, 0, 0, 0, 0, "R9 doubled prefix alternate");
    drive(2'd1, 0, 0, 5'd7, 5'd8, 5'd9, 0, "R9 after pair unprefixed");
    drive(2'd3, 1, 10'h2aa, 0, 0, 0, 0, "R9 first");
    drive(2'd2, 1, 10'h155, 0, 0, 0, 0, "R9 doubled 48-bit second");
    drive(2'd2, 1, mk(3'd4, 0, 2'd2, 2'd1, 2'd0), 0, 0, 0, 0, "R9 third starts new");
    drive(2'd1, 0, 0, 5'd11, 5'd12, 5'd13, 0, "R9 third prefix applies");

    drive(2'd2, 1, mk(3'd5, 0, 2'd3, 2'd3, 2'd3), 0, 0, 0, 0, "R10 prefix");
    drive(2'd1, 0, 0, 5'd1, 5'd1, 5'd1, 1, "R10 flushed word");
    drive(2'd1, 0, 0, 5'd2, 5'd3, 5'd4, 0, "R10 after flush unprefixed");
    drive(2'd2, 1, mk(3'd5, 0, 2'd3, 2'd3, 2'd3), 0, 0, 0, 0, "R10 prefix");
    drive(2'd2, 1, 10'h0ff, 0, 0, 0, 1, "R10 flushed second prefix");
    drive(2'd2, 1, mk(3'd6, 1, 2'd0, 2'd1, 2'd2), 0, 0, 0, 0, "R10 fresh prefix");
    drive(2'd0, 0, 0, 5'd7, 5'd7, 5'd7, 0, "R10 no alternate after flush");
    idle(4);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 missing results: actual %0d outstanding expected 0", sb.size());
    end
    summary();
  end
endmodule